// File: doc/BRIEF.md
# Stack Push/Pull Sequencer for an 8-bit CPU

This block runs the stack traffic of a small accumulator CPU: subroutine call and return, hardware interrupt entry and return, the software break, and the push and pull of the status byte. The decoder hands it one operation per transfer on a valid/ready request channel. An operation is held while `op_valid` is high and `op_ready` is low, and it transfers on a rising edge where both are high. `op_kind`, `op_target`, `pc_in` and `stat_in` must stay stable from that edge until `seq_done`. The block then drives a one-byte-per-cycle memory port. Writes take effect at the clock edge that ends the cycle. Read data must be valid combinationally within the cycle in which the address is presented. When the sequence ends, the block reports the new program counter and status for one cycle.

The stack occupies one page, selected by `STACK_PAGE` (default 0x01). The stack pointer starts at `SP_INIT` (0xFF). Maskable requests arrive on a level input. Non-maskable requests are latched on a rising edge.

The `LEGACY` parameter chooses between two behaviours. With `LEGACY` set to 1, the block keeps the older behaviour: interrupt entry leaves the decimal flag alone, and an interrupt that arrives during a break steals the break. With `LEGACY` set to 0, both are corrected.

Status byte bits, from bit 7 down to bit 0: N, V, 1, B, D, I, Z, C.

Top module: `stack_seq`

## Requirements
- R1: After reset, `sp_out` is 0xFF, `op_ready` is 1, and `bus_we`, `bus_re` and `seq_done` are 0.
- R2: A push writes to address {STACK_PAGE, SP} and then decrements SP. A pull first increments SP and then reads {STACK_PAGE, SP}.
- R3: Call (op_kind 0) writes (pc_in − 1) to the stack, high byte first then low byte. It completes with `pc_we`=1 and `pc_out`=`op_target`, and does not update status.
- R4: Return (op_kind 1) pulls the low byte, then the high byte, and outputs the pulled address plus one.
- R5: Interrupt return (op_kind 2) pulls the status byte, then the low byte, then the high byte. It outputs the pulled address unchanged. The restored status has bit 5 = 1 and bit 4 taken from `stat_in`.
- R6: Status push (op_kind 4) writes `stat_in` with bits 4 and 5 set. It asserts neither `pc_we` nor `stat_we`.
- R7: Status pull (op_kind 5) outputs the pulled byte with bit 5 forced to 1 and bit 4 taken from `stat_in`. The stored bit 4 is ignored.
- R8: If `irq` is high and `stat_in` bit 2 (I) is 0, the block pushes PC high, then PC low, then status with bit 4 = 0 and bit 5 = 1. It then reads the vector at 0xFFFE (low byte) and 0xFFFF (high byte), and outputs status with I set. If I is 1, `irq` has no effect.
- R9: A rising edge on `nmi` causes the same entry sequence as R8, but through the vector at 0xFFFA/0xFFFB. This happens regardless of I. A pending non-maskable request wins over `irq` and over a waiting op.
- R10: Break (op_kind 3) pushes PC high, then PC low, then status with bits 4 and 5 set. It then vectors through 0xFFFE and sets I.
- R11: With `LEGACY`=1, interrupt and break entry leave D (bit 3) unchanged. With `LEGACY`=0, they clear D.
- R12: With `LEGACY`=1, if a non-maskable request is pending during either PC push of a break, the status pushed has bit 4 = 0 and the 0xFFFA vector is used, and no second entry follows. With `LEGACY`=0, the break completes with bit 4 = 1 through 0xFFFE, and the non-maskable entry follows after it.
- R13: `op_ready` is 0 from the transfer edge until the sequence ends. `seq_done` is a one-cycle pulse. No bus access happens while `op_ready` is 1. Op_kind codes 6 and 7 are accepted and then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request valid |
| op_ready | output | 1 | Request accepted when high with op_valid |
| op_kind | input | 3 | 0 call, 1 return, 2 int return, 3 break, 4 status push, 5 status pull |
| op_target | input | 16 | Call destination |
| irq | input | 1 | Maskable request, level |
| nmi | input | 1 | Non-maskable request, rising edge |
| pc_in | input | 16 | Resume address (next instruction) |
| stat_in | input | 8 | Current status byte |
| bus_addr | output | 16 | Memory address |
| bus_wdata | output | 8 | Memory write data |
| bus_we | output | 1 | Memory write strobe |
| bus_re | output | 1 | Memory read strobe |
| bus_rdata | input | 8 | Memory read data, same cycle |
| sp_out | output | 8 | Stack pointer |
| pc_out | output | 16 | New program counter |
| pc_we | output | 1 | pc_out valid this cycle |
| stat_out | output | 8 | New status byte |
| stat_we | output | 1 | stat_out valid this cycle |
| seq_done | output | 1 | Sequence finished this cycle |

## Verification
The properties assume that `stat_in` and `op_kind` do not change during a sequence, and that read data belongs to the address presented in the same cycle. The stimulus therefore changes inputs only on falling edges while the block is idle, and serves reads combinationally from a one-page stack model plus fixed vector bytes. `nmi` is driven as a pulse of one cycle. `irq` is withdrawn once entry has begun, so that a request is taken only once even though the bench never sets I itself.

// File: rtl/stk_seq_pkg.sv
package stk_seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_PUSH_H, S_PUSH_L, S_PUSH_P,
    S_VEC_L, S_VEC_H, S_PULL_P, S_PULL_L, S_PULL_H, S_FIN
  } seq_state_t;

  typedef enum logic [2:0] {
    K_CALL = 3'd0, K_RET = 3'd1, K_RTI = 3'd2, K_BRK = 3'd3,
    K_PHP = 3'd4, K_PLP = 3'd5, K_INT = 3'd6, K_NONE = 3'd7
  } seq_kind_t;

  localparam int unsigned SW    = 8;
  localparam int unsigned BIT_I = 2;
  localparam int unsigned BIT_D = 3;
  localparam int unsigned BIT_B = 4;
  localparam int unsigned BIT_U = 5;
endpackage

// File: rtl/stk_ptr.sv
module stk_ptr #(
  parameter int unsigned    DW   = 8,
  parameter logic [DW-1:0]  INIT = 8'hFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pull,
  output logic [DW-1:0] sp,
  output logic [DW-1:0] slot
);
  // a pull pre-increments, so it addresses the slot above
  assign slot = pull ? sp + DW'(1) : sp;

  always_ff @(posedge clk) begin
    if (!rst_n)    sp <= INIT;
    else if (push) sp <= sp - DW'(1);
    else if (pull) sp <= sp + DW'(1);
  end
endmodule

// File: rtl/nmi_catch.sv
module nmi_catch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi,
  input  logic clr,
  output logic pend
);
  logic nmi_q;
  logic rise;

  assign rise = nmi & ~nmi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      nmi_q <= nmi;
      pend  <= (pend & ~clr) | rise;
    end
  end
endmodule

// File: rtl/stat_fmt.sv
module stat_fmt
  import stk_seq_pkg::*;
#(
  parameter bit LEGACY = 1'b1
) (
  input  logic [SW-1:0] cur,
  input  logic [SW-1:0] pulled,
  output logic [SW-1:0] push_soft,
  output logic [SW-1:0] push_hard,
  output logic [SW-1:0] entered,
  output logic [SW-1:0] restored
);
  localparam logic [SW-1:0] M_B = SW'(1) << BIT_B;
  localparam logic [SW-1:0] M_U = SW'(1) << BIT_U;
  localparam logic [SW-1:0] M_I = SW'(1) << BIT_I;
  localparam logic [SW-1:0] M_D = SW'(1) << BIT_D;

  assign push_soft = cur | M_B | M_U;
  assign push_hard = (cur | M_U) & ~M_B;
  assign restored  = (pulled & ~(M_B | M_U)) | M_U | (cur & M_B);

  generate
    if (LEGACY) begin : g_keep_d
      assign entered = cur | M_I;
    end else begin : g_clear_d
      assign entered = (cur | M_I) & ~M_D;
    end
  endgenerate
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stk_seq_pkg::*;
#(
  parameter bit                 LEGACY     = 1'b1,
  parameter int unsigned        DW         = 8,
  parameter logic [DW-1:0]      STACK_PAGE = 8'h01,
  parameter logic [DW-1:0]      SP_INIT    = 8'hFF,
  parameter logic [2*DW-1:0]    NMI_VEC    = 16'hFFFA,
  parameter logic [2*DW-1:0]    IRQ_VEC    = 16'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [2:0]        op_kind,
  input  logic [2*DW-1:0]   op_target,
  input  logic              irq,
  input  logic              nmi,
  input  logic [2*DW-1:0]   pc_in,
  input  logic [7:0]        stat_in,
  output logic [2*DW-1:0]   bus_addr,
  output logic [DW-1:0]     bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DW-1:0]     bus_rdata,
  output logic [DW-1:0]     sp_out,
  output logic [2*DW-1:0]   pc_out,
  output logic              pc_we,
  output logic [7:0]        stat_out,
  output logic              stat_we,
  output logic              seq_done
);
  localparam int unsigned AW = 2 * DW;

  seq_state_t     state;
  seq_kind_t      kind_q;
  logic [AW-1:0]  pc_q, pc_new_q;
  logic [SW-1:0]  st_q, ph_q;
  logic [DW-1:0]  lo_q;
  logic           is_nmi_q, lost_q;

  logic           sp_push, sp_pull;
  logic [DW-1:0]  slot;
  logic           nmi_pend, nmi_clr;
  logic           int_go, hijack;
  logic [AW-1:0]  vec_base;
  logic [SW-1:0]  push_soft, push_hard, entered, restored;

  stk_ptr #(.DW(DW), .INIT(SP_INIT)) u_sp (
    .clk(clk), .rst_n(rst_n), .push(sp_push), .pull(sp_pull),
    .sp(sp_out), .slot(slot)
  );

  nmi_catch u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi(nmi), .clr(nmi_clr), .pend(nmi_pend)
  );

  stat_fmt #(.LEGACY(LEGACY)) u_fmt (
    .cur(st_q), .pulled(ph_q), .push_soft(push_soft),
    .push_hard(push_hard), .entered(entered), .restored(restored)
  );

  assign int_go   = nmi_pend | (irq & ~stat_in[BIT_I]);
  assign op_ready = (state == S_IDLE) && !int_go;
  assign vec_base = is_nmi_q ? NMI_VEC : IRQ_VEC;

  // older behaviour: a request seen during the break's PC pushes takes it over
  assign hijack = LEGACY && (kind_q == K_BRK) && !lost_q &&
                  ((state == S_PUSH_H) || (state == S_PUSH_L)) &&
                  (nmi_pend || (irq && !st_q[BIT_I]));

  assign nmi_clr = ((state == S_IDLE) && nmi_pend) || (hijack && nmi_pend);

  // bus side
  always_comb begin
    bus_addr  = '0;
    bus_wdata = '0;
    bus_we    = 1'b0;
    bus_re    = 1'b0;
    sp_push   = 1'b0;
    sp_pull   = 1'b0;
    unique case (state)
      S_PUSH_H, S_PUSH_L, S_PUSH_P: begin
        bus_we   = 1'b1;
        sp_push  = 1'b1;
        bus_addr = {STACK_PAGE, slot};
        if (state == S_PUSH_H)      bus_wdata = pc_q[AW-1:DW];
        else if (state == S_PUSH_L) bus_wdata = pc_q[DW-1:0];
        else if ((kind_q == K_INT) || lost_q) bus_wdata = DW'(push_hard);
        else                        bus_wdata = DW'(push_soft);
      end
      S_VEC_L: begin
        bus_re   = 1'b1;
        bus_addr = vec_base;
      end
      S_VEC_H: begin
        bus_re   = 1'b1;
        bus_addr = vec_base + AW'(1);
      end
      S_PULL_P, S_PULL_L, S_PULL_H: begin
        bus_re   = 1'b1;
        sp_pull  = 1'b1;
        bus_addr = {STACK_PAGE, slot};
      end
      default: ;
    endcase
  end

  // completion side
  always_comb begin
    seq_done = (state == S_FIN);
    pc_out   = pc_new_q;
    pc_we    = seq_done && (kind_q inside {K_CALL, K_RET, K_RTI, K_BRK, K_INT});
    stat_we  = seq_done && (kind_q inside {K_RTI, K_PLP, K_BRK, K_INT});
    stat_out = (kind_q inside {K_RTI, K_PLP}) ? restored : entered;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      kind_q   <= K_NONE;
      pc_q     <= '0;
      pc_new_q <= '0;
      st_q     <= '0;
      ph_q     <= '0;
      lo_q     <= '0;
      is_nmi_q <= 1'b0;
      lost_q   <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: begin
          lost_q <= 1'b0;
          if (int_go) begin
            kind_q   <= K_INT;
            is_nmi_q <= nmi_pend;
            pc_q     <= pc_in;
            st_q     <= stat_in;
            state    <= S_PUSH_H;
          end else if (op_valid) begin
            is_nmi_q <= 1'b0;
            st_q     <= stat_in;
            pc_q     <= (op_kind == K_CALL) ? pc_in - AW'(1) : pc_in;
            pc_new_q <= op_target;
            case (op_kind)
              K_CALL, K_BRK: begin kind_q <= seq_kind_t'(op_kind); state <= S_PUSH_H; end
              K_RET:         begin kind_q <= K_RET;                state <= S_PULL_L; end
              K_RTI, K_PLP:  begin kind_q <= seq_kind_t'(op_kind); state <= S_PULL_P; end
              K_PHP:         begin kind_q <= K_PHP;                state <= S_PUSH_P; end
              default:       kind_q <= K_NONE;
            endcase
          end
        end
        S_PUSH_H, S_PUSH_L: begin
          if (hijack) begin
            lost_q   <= 1'b1;
            is_nmi_q <= nmi_pend;
          end
          if (state == S_PUSH_H)      state <= S_PUSH_L;
          else if (kind_q == K_CALL)  state <= S_FIN;
          else                        state <= S_PUSH_P;
        end
        S_PUSH_P: state <= (kind_q == K_PHP) ? S_FIN : S_VEC_L;
        S_VEC_L: begin
          lo_q  <= bus_rdata;
          state <= S_VEC_H;
        end
        S_VEC_H: begin
          pc_new_q <= {bus_rdata, lo_q};
          state    <= S_FIN;
        end
        S_PULL_P: begin
          ph_q  <= SW'(bus_rdata);
          state <= (kind_q == K_PLP) ? S_FIN : S_PULL_L;
        end
        S_PULL_L: begin
          lo_q  <= bus_rdata;
          state <= S_PULL_H;
        end
        S_PULL_H: begin
          pc_new_q <= {bus_rdata, lo_q} + AW'(kind_q == K_RET);
          state    <= S_FIN;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk
  import stk_seq_pkg::*;
#(
  parameter bit            LEGACY     = 1'b1,
  parameter int unsigned   DW         = 8,
  parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_ready,
  input logic              bus_we,
  input logic              bus_re,
  input logic [2*DW-1:0]   bus_addr,
  input logic [DW-1:0]     bus_wdata,
  input logic [DW-1:0]     sp_out,
  input logic              seq_done,
  input logic              stat_we,
  input logic [7:0]        stat_out,
  input seq_state_t        state,
  input seq_kind_t         kind
);
  // R2
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_addr == {STACK_PAGE, sp_out});
  // R2
  push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> sp_out == $past(sp_out) - DW'(1));
  // R2
  pull_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr[2*DW-1:DW] == STACK_PAGE) |=> sp_out == $past(sp_out) + DW'(1));
  // R6
  stat_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PUSH_P && bus_we) |-> bus_wdata[BIT_U]);
  // R8
  hard_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PUSH_P && bus_we && kind == K_INT) |-> !bus_wdata[BIT_B]);
  // R10
  brk_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!LEGACY && state == S_PUSH_P && bus_we && kind == K_BRK) |-> bus_wdata[BIT_B]);
  // R8
  int_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_we && kind == K_INT) |-> stat_out[BIT_I]);
  // R11
  cmos_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!LEGACY && stat_we && (kind == K_INT || kind == K_BRK)) |-> !stat_out[BIT_D]);
  // R13
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_ready |-> (!bus_we && !bus_re));
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);
endmodule

bind stack_seq stack_seq_chk #(.LEGACY(LEGACY), .DW(DW), .STACK_PAGE(STACK_PAGE)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_ready(op_ready), .bus_we(bus_we),
  .bus_re(bus_re), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .sp_out(sp_out), .seq_done(seq_done), .stat_we(stat_we),
  .stat_out(stat_out), .state(state), .kind(kind_q)
);

// File: tb/sim_stack_seq.sv
module sim_mem (
  input  logic        clk,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  input  logic        we,
  output logic [7:0]  rdata
);
  logic [7:0] stk [0:255];
  initial for (int i = 0; i < 256; i++) stk[i] = 8'h00;
  always @(posedge clk) if (we && addr[15:8] == 8'h01) stk[addr[7:0]] <= wdata;
  always_comb begin
    case (addr)
      16'hFFFA: rdata = 8'h23;
      16'hFFFB: rdata = 8'hC1;
      16'hFFFE: rdata = 8'h56;
      16'hFFFF: rdata = 8'hD4;
      default:  rdata = (addr[15:8] == 8'h01) ? stk[addr[7:0]] : 8'h00;
    endcase
  end
endmodule

module sim_stack_seq;
  typedef struct {
    string       tag;
    logic        pcw;
    logic [15:0] pc;
    logic        stw;
    logic [7:0]  st;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [2:0] op_kind = 3'd0;
  logic [15:0] op_target = 16'h0;
  logic irq = 1'b0, nmi = 1'b0;
  logic [15:0] pc_in = 16'h0;
  logic [7:0] stat_in = 8'h0;

  logic [15:0] a0, a1, pco0, pco1;
  logic [7:0]  wd0, wd1, rd0, rd1, sp0, sp1, so0, so1;
  logic we0, we1, re0, re1, rdy0, rdy1, pw0, pw1, sw0, sw1, dn0, dn1;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  exp_t q0[$], q1[$];

  always #5 clk = ~clk;

  stack_seq #(.LEGACY(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(rdy0),
    .op_kind(op_kind), .op_target(op_target), .irq(irq), .nmi(nmi),
    .pc_in(pc_in), .stat_in(stat_in), .bus_addr(a0), .bus_wdata(wd0),
    .bus_we(we0), .bus_re(re0), .bus_rdata(rd0), .sp_out(sp0),
    .pc_out(pco0), .pc_we(pw0), .stat_out(so0), .stat_we(sw0), .seq_done(dn0)
  );
  stack_seq #(.LEGACY(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(rdy1),
    .op_kind(op_kind), .op_target(op_target), .irq(irq), .nmi(nmi),
    .pc_in(pc_in), .stat_in(stat_in), .bus_addr(a1), .bus_wdata(wd1),
    .bus_we(we1), .bus_re(re1), .bus_rdata(rd1), .sp_out(sp1),
    .pc_out(pco1), .pc_we(pw1), .stat_out(so1), .stat_we(sw1), .seq_done(dn1)
  );
  sim_mem m0 (.clk(clk), .addr(a0), .wdata(wd0), .we(we0), .rdata(rd0));
  sim_mem m1 (.clk(clk), .addr(a1), .wdata(wd1), .we(we1), .rdata(rd1));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expb(input string t, input logic pcw, input logic [15:0] pc,
                      input logic stw, input logic [7:0] s0, input logic [7:0] s1);
    exp_t e;
    e.tag = t; e.pcw = pcw; e.pc = pcw ? pc : 16'h0; e.stw = stw;
    e.st = stw ? s0 : 8'h0;
    q0.push_back(e);
    e.st = stw ? s1 : 8'h0;
    q1.push_back(e);
  endtask

  task automatic compare(input exp_t e, input logic pw, input logic [15:0] pc,
                         input logic sw, input logic [7:0] so, input string who);
    logic [25:0] act, exp;
    act = {pw, pw ? pc : 16'h0, sw, sw ? so : 8'h0};
    exp = {e.pcw, e.pc, e.stw, e.st};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", e.tag, who, act, exp);
    end
  endtask

  // monitor: pops one expected completion per done pulse
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (dn0) begin
        if (q0.size() == 0) chk("R13 u0 unexpected done", 32'd1, 32'd0);
        else compare(q0.pop_front(), pw0, pco0, sw0, so0, "u0");
      end
      if (dn1) begin
        if (q1.size() == 0) chk("R13 u1 unexpected done", 32'd1, 32'd0);
        else compare(q1.pop_front(), pw1, pco1, sw1, so1, "u1");
      end
    end
  end

  task automatic send(input logic [2:0] k, input logic [15:0] tgt);
    @(negedge clk);
    op_kind = k; op_target = tgt; op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    while (!(rdy0 && rdy1)) @(negedge clk);
  endtask

  task automatic summary();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sp", {24'h0, sp0}, 32'hFF);
    chk("R1 ready", {31'h0, rdy0}, 32'd1);
    chk("R1 bus idle", {30'h0, we0, re0}, 32'd0);
    chk("R1 done", {31'h0, dn0}, 32'd0);

    // R3 call
    pc_in = 16'h1236;
    expb("R3", 1'b1, 16'h2000, 1'b0, 8'h0, 8'h0);
    send(3'd0, 16'h2000);
    chk("R13 ready low while busy", {31'h0, rdy0}, 32'd0);
    settle();
    chk("R3 hi byte", {24'h0, m0.stk[8'hFF]}, 32'h12);
    chk("R3 lo byte", {24'h0, m0.stk[8'hFE]}, 32'h35);
    chk("R2 sp after call", {24'h0, sp0}, 32'hFD);

    // R4 return
    expb("R4", 1'b1, 16'h1236, 1'b0, 8'h0, 8'h0);
    send(3'd1, 16'h0);
    settle();
    chk("R2 sp after return", {24'h0, sp1}, 32'hFF);

    // R6 status push
    stat_in = 8'hC3;
    expb("R6", 1'b0, 16'h0, 1'b0, 8'h0, 8'h0);
    send(3'd4, 16'h0);
    settle();
    chk("R6 pushed byte", {24'h0, m0.stk[8'hFF]}, 32'hF3);
    chk("R2 sp after push", {24'h0, sp0}, 32'hFE);

    // R7 status pull ignores stored bit 4
    stat_in = 8'h00;
    m0.stk[8'hFF] = 8'hDF; m1.stk[8'hFF] = 8'hDF;
    expb("R7", 1'b0, 16'h0, 1'b1, 8'hEF, 8'hEF);
    send(3'd5, 16'h0);
    settle();
    chk("R7 sp after pull", {24'h0, sp0}, 32'hFF);

    // R8 masked request is ignored
    stat_in = 8'h04; irq = 1'b1;
    repeat (6) @(negedge clk);
    chk("R8 masked sp", {24'h0, sp0}, 32'hFF);
    chk("R8 masked ready", {31'h0, rdy0}, 32'd1);
    irq = 1'b0;

    // R8 R11 maskable entry
    stat_in = 8'h08; pc_in = 16'h3456;
    expb("R8 R11", 1'b1, 16'hD456, 1'b1, 8'h0C, 8'h04);
    @(negedge clk); irq = 1'b1;
    @(negedge clk); irq = 1'b0;
    settle();
    chk("R8 pc hi", {24'h0, m0.stk[8'hFF]}, 32'h34);
    chk("R8 pc lo", {24'h0, m0.stk[8'hFE]}, 32'h56);
    chk("R8 stat pushed", {24'h0, m1.stk[8'hFD]}, 32'h28);
    chk("R8 sp", {24'h0, sp1}, 32'hFC);

    // R5 interrupt return
    stat_in = 8'h04;
    expb("R5", 1'b1, 16'h3456, 1'b1, 8'h28, 8'h28);
    send(3'd2, 16'h0);
    settle();
    chk("R5 sp", {24'h0, sp0}, 32'hFF);

    // R9 non-maskable entry with I set
    stat_in = 8'h04; pc_in = 16'h4000;
    expb("R9", 1'b1, 16'hC123, 1'b1, 8'h04, 8'h04);
    @(negedge clk); nmi = 1'b1;
    @(negedge clk); nmi = 1'b0;
    settle();
    chk("R9 stat pushed", {24'h0, m0.stk[8'hFD]}, 32'h24);
    expb("R5", 1'b1, 16'h4000, 1'b1, 8'h24, 8'h24);
    send(3'd2, 16'h0);
    settle();

    // R10 R11 break
    stat_in = 8'h08; pc_in = 16'h5002;
    expb("R10 R11", 1'b1, 16'hD456, 1'b1, 8'h0C, 8'h04);
    send(3'd3, 16'h0);
    settle();
    chk("R10 stat pushed u0", {24'h0, m0.stk[8'hFD]}, 32'h38);
    chk("R10 stat pushed u1", {24'h0, m1.stk[8'hFD]}, 32'h38);
    expb("R5", 1'b1, 16'h5002, 1'b1, 8'h28, 8'h28);
    send(3'd2, 16'h0);
    settle();

    // R12 break meets non-maskable request
    stat_in = 8'h00; pc_in = 16'h6000;
    begin
      exp_t e;
      e.tag = "R12"; e.pcw = 1'b1; e.pc = 16'hC123; e.stw = 1'b1; e.st = 8'h04;
      q0.push_back(e);
      e.pc = 16'hD456; q1.push_back(e);
      e.pc = 16'hC123; q1.push_back(e);
    end
    @(negedge clk); op_kind = 3'd3; op_valid = 1'b1;
    @(negedge clk); op_valid = 1'b0; nmi = 1'b1;
    @(negedge clk); nmi = 1'b0;
    settle();
    chk("R12 legacy stat pushed", {24'h0, m0.stk[8'hFD]}, 32'h20);
    chk("R12 legacy sp", {24'h0, sp0}, 32'hFC);
    chk("R12 fixed brk stat", {24'h0, m1.stk[8'hFD]}, 32'h30);
    chk("R12 fixed nmi stat", {24'h0, m1.stk[8'hFA]}, 32'h20);
    chk("R12 fixed sp", {24'h0, sp1}, 32'hF9);
    repeat (5) @(negedge clk);
    chk("R12 no second entry", {24'h0, sp0}, 32'hFC);

    // R13 unused code is ignored
    send(3'd7, 16'h0);
    repeat (4) @(negedge clk);
    chk("R13 unused code sp", {24'h0, sp0}, 32'hFC);
    chk("R13 unused code ready", {31'h0, rdy0}, 32'd1);
    chk("R13 all completions seen", q0.size() + q1.size(), 32'd0);

    summary();
  end
endmodule